// File: doc/BRIEF.md
# Reference-Clocked Seconds Counter with Match Interrupt

This block keeps a free-running 32-bit count of a slow reference clock (nominally 32.768 kHz) that arrives on its own pin, asynchronous to the system clock. A synchroniser and rising-edge detector turn each reference edge into a single one-cycle increment pulse in the system clock domain. Software programs a compare value. When the count steps onto that value, a sticky raw status bit is set. The status bit, gated by a mask bit, drives a registered interrupt output.

A match does not stop or reload the counter. Counting stops only when software disables it or reset is applied. A write to the load register restarts the count from any chosen value. From there it runs up to all-ones and wraps to zero. A stall control lets a debug-halt input freeze the count.

The register map is on a 3-bit word address. Writes take effect at the clock edge on which `reg_we` is high. Reads are registered, so `reg_rdata` shows the addressed register one cycle after `reg_raddr` is presented. The map is:

- 0: mode, bits [2:0]. Code 1 selects counting operation.
- 1: control. Bit 0 is run and bit 1 is stall.
- 2: compare value.
- 3: load. A write sets the count; a read returns the live count.
- 4: mask, bit 0.
- 5: status. Bit 0 is raw and bit 1 is masked.
- 6: clear. Writing 1 to bit 0 clears the status; reads return 0.

Top module: `rtc_match_counter`

## Requirements
- R1: The count advances only while the mode register (address 0) holds code 1 and the run bit (bit 0 of address 1) is set. With any other mode code the count holds.
- R2: The count advances by exactly one for each rising edge of `ref_clk_in`. Holding the reference level high for many system clocks adds only one.
- R3: When an increment brings the count equal to the compare value (address 2), status bit 0 at address 5 is set. The count then keeps advancing past the compare value.
- R4: Writing 1 to bit 0 of address 6 clears the status. If that write falls in the same cycle as a new match, the status stays set.
- R5: A write to address 3 replaces the count with the written value at any time. The count wraps from 0xFFFFFFFF to 0, and a compare value of 0 matches on that wrap.
- R6: `irq_o` is high only while the status is set and mask bit 0 at address 4 is set. It follows the status one cycle later.
- R7: While stall (bit 1 of address 1) and `dbg_halt` are both high, reference edges are not counted. `dbg_halt` alone has no effect.
- R8: While the run bit is set, writes to the mode register and to the compare register are ignored.
- R9: After reset, the count, control, status and `irq_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk_in | input | 1 | Asynchronous slow reference clock |
| dbg_halt | input | 1 | Debug halt request, honoured when stall is set |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Write word address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 3 | Read word address |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Registered masked interrupt |

## Verification
A status-clear write and a fresh compare hit can land on the same system clock edge. The bench provokes this by loading the count one below the compare value. It then raises the reference input and issues the clear write exactly three system clocks later, which is the edge on which the incremented count is first compared. The status read back afterwards must still be set. A separate clear issued with no increment nearby must return it to zero.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADR_MODE  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_CTRL  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CMP   = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_LOAD  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_MASK  = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_STAT  = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_CLR   = 3'd6;
  localparam int MODE_W = 3;
  localparam logic [MODE_W-1:0] MODE_COUNT = 3'd1;
  localparam int CTRL_RUN_BIT   = 0;
  localparam int CTRL_STALL_BIT = 1;
endpackage

// File: rtl/rtc_ref_sync.sv
module rtc_ref_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    genvar gi;
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[gi] <= 1'b0;
          else     chain_q[gi] <= chain_q[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/rtc_count_core.sv
module rtc_count_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  input  logic         run_i,
  input  logic         freeze_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] count_o,
  output logic         adv_o
);
  logic [W-1:0] count_q;
  logic         adv_q;
  logic         step;

  assign step = tick_i & run_i & ~freeze_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      adv_q   <= 1'b0;
    end else if (load_i) begin
      count_q <= load_val_i;
      adv_q   <= 1'b0;
    end else if (step) begin
      count_q <= count_q + {{(W-1){1'b0}}, 1'b1};
      adv_q   <= 1'b1;
    end else begin
      adv_q   <= 1'b0;
    end
  end

  assign count_o = count_q;
  assign adv_o   = adv_q;
endmodule

// File: rtl/rtc_match_irq.sv
module rtc_match_irq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv_i,
  input  logic [W-1:0] count_i,
  input  logic [W-1:0] match_i,
  input  logic         clr_i,
  input  logic         mask_i,
  output logic         status_o,
  output logic         irq_o
);
  logic status_q;
  logic irq_q;
  logic hit;

  assign hit = adv_i && (count_i == match_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (hit)        status_q <= 1'b1;
      else if (clr_i) status_q <= 1'b0;
      irq_q <= status_q & mask_i;
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/rtc_match_counter.sv
module rtc_match_counter
  import rtc_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ref_clk_in,
  input  logic                dbg_halt,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_waddr,
  input  logic [DATA_W-1:0]   reg_wdata,
  input  logic [ADDR_W-1:0]   reg_raddr,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                irq_o
);
  logic [MODE_W-1:0] mode_q;
  logic              ctrl_run;
  logic              ctrl_stall;
  logic [DATA_W-1:0] cmp_q;
  logic              mask_q;
  logic              mode_wr, ctrl_wr, cmp_wr, load_wr, mask_wr, clr_wr;
  logic              tick;
  logic [DATA_W-1:0] cnt_val;
  logic              cnt_adv;
  logic              stat_raw;
  logic [DATA_W-1:0] rd_mux;

  assign mode_wr = reg_we && (reg_waddr == ADR_MODE);
  assign ctrl_wr = reg_we && (reg_waddr == ADR_CTRL);
  assign cmp_wr  = reg_we && (reg_waddr == ADR_CMP);
  assign load_wr = reg_we && (reg_waddr == ADR_LOAD);
  assign mask_wr = reg_we && (reg_waddr == ADR_MASK);
  assign clr_wr  = reg_we && (reg_waddr == ADR_CLR) && reg_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= '0;
      ctrl_run   <= 1'b0;
      ctrl_stall <= 1'b0;
      cmp_q      <= '0;
      mask_q     <= 1'b0;
    end else begin
      if (mode_wr && !ctrl_run) mode_q <= reg_wdata[MODE_W-1:0];
      if (cmp_wr && !ctrl_run)  cmp_q  <= reg_wdata;
      if (ctrl_wr) begin
        ctrl_run   <= reg_wdata[CTRL_RUN_BIT];
        ctrl_stall <= reg_wdata[CTRL_STALL_BIT];
      end
      if (mask_wr) mask_q <= reg_wdata[0];
    end
  end

  rtc_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_in(ref_clk_in),
    .rise_o  (tick)
  );

  rtc_count_core #(.W(DATA_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick),
    .run_i     (ctrl_run && (mode_q == MODE_COUNT)),
    .freeze_i  (ctrl_stall && dbg_halt),
    .load_i    (load_wr),
    .load_val_i(reg_wdata),
    .count_o   (cnt_val),
    .adv_o     (cnt_adv)
  );

  rtc_match_irq #(.W(DATA_W)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .adv_i   (cnt_adv),
    .count_i (cnt_val),
    .match_i (cmp_q),
    .clr_i   (clr_wr),
    .mask_i  (mask_q),
    .status_o(stat_raw),
    .irq_o   (irq_o)
  );

  always_comb begin
    rd_mux = '0;
    case (reg_raddr)
      ADR_MODE: rd_mux[MODE_W-1:0] = mode_q;
      ADR_CTRL: begin
        rd_mux[CTRL_RUN_BIT]   = ctrl_run;
        rd_mux[CTRL_STALL_BIT] = ctrl_stall;
      end
      ADR_CMP:  rd_mux = cmp_q;
      ADR_LOAD: rd_mux = cnt_val;
      ADR_MASK: rd_mux[0] = mask_q;
      ADR_STAT: begin
        rd_mux[0] = stat_raw;
        rd_mux[1] = stat_raw & mask_q;
      end
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/rtc_match_counter_chk.sv
module rtc_match_counter_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] cnt_val,
  input logic         load_wr,
  input logic         ctrl_stall,
  input logic         ctrl_run,
  input logic         dbg_halt,
  input logic         stat_raw,
  input logic         clr_wr,
  input logic         mask_q,
  input logic         irq_o,
  input logic [2:0]   mode_q,
  input logic         mode_wr,
  input logic         cmp_wr,
  input logic [W-1:0] cmp_q
);
  assert_mode_holds_R1: assert property (@(posedge clk) disable iff (rst)
    (mode_q != 3'd1 && !load_wr) |=> $stable(cnt_val));

  assert_single_step_R2: assert property (@(posedge clk) disable iff (rst)
    !load_wr |=> (cnt_val == $past(cnt_val) || cnt_val == $past(cnt_val) + 1'b1));

  assert_status_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (stat_raw && !clr_wr) |=> stat_raw);

  assert_irq_masked_R6: assert property (@(posedge clk) disable iff (rst)
    !mask_q |=> !irq_o);

  assert_stall_freeze_R7: assert property (@(posedge clk) disable iff (rst)
    (ctrl_stall && dbg_halt && !load_wr) |=> $stable(cnt_val));

  assert_mode_locked_R8: assert property (@(posedge clk) disable iff (rst)
    (ctrl_run && mode_wr) |=> $stable(mode_q));

  assert_cmp_locked_R8: assert property (@(posedge clk) disable iff (rst)
    (ctrl_run && cmp_wr) |=> $stable(cmp_q));
endmodule

bind rtc_match_counter rtc_match_counter_chk #(.W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cnt_val   (cnt_val),
  .load_wr   (load_wr),
  .ctrl_stall(ctrl_stall),
  .ctrl_run  (ctrl_run),
  .dbg_halt  (dbg_halt),
  .stat_raw  (stat_raw),
  .clr_wr    (clr_wr),
  .mask_q    (mask_q),
  .irq_o     (irq_o),
  .mode_q    (mode_q),
  .mode_wr   (mode_wr),
  .cmp_wr    (cmp_wr),
  .cmp_q     (cmp_q)
);

// File: tb/rtc_match_counter_tb.sv
module rtc_match_counter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 5;
  localparam logic [31:0] V_LOAD [NV] = '{32'd10, 32'd10, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'd100};
  localparam logic [31:0] V_CMP  [NV] = '{32'd13, 32'd20, 32'd0, 32'd5, 32'd101};
  localparam int          V_NPUL [NV] = '{3, 3, 2, 1, 4};
  localparam logic [31:0] V_CNT  [NV] = '{32'd13, 32'd13, 32'd0, 32'd0, 32'd104};
  localparam logic        V_STAT [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_clk_in = 1'b0;
  logic        dbg_halt = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [2:0]  reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_match_counter u_dut (
    .clk(clk), .rst(rst), .ref_clk_in(ref_clk_in), .dbg_halt(dbg_halt),
    .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_raddr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic pulse();
    ref_clk_in = 1'b1;
    repeat (4) @(negedge clk);
    ref_clk_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic setup(input logic [31:0] ld, input logic [31:0] cm);
    wr(3'd1, 32'd0);
    wr(3'd0, 32'd1);
    wr(3'd2, cm);
    wr(3'd3, ld);
    wr(3'd6, 32'd1);
    wr(3'd1, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    rd(3'd3, rv); chk("R9 count", rv, 32'd0);
    rd(3'd1, rv); chk("R9 ctrl", rv, 32'd0);
    rd(3'd5, rv); chk("R9 status", rv, 32'd0);
    chk("R9 irq", {31'd0, irq_o}, 32'd0);

    // vector table: R3 match, R5 load and wrap
    for (int i = 0; i < NV; i++) begin
      setup(V_LOAD[i], V_CMP[i]);
      for (int p = 0; p < V_NPUL[i]; p++) pulse();
      rd(3'd3, rv); chk("R5 R3 vector count", rv, V_CNT[i]);
      rd(3'd5, rv); chk("R3 vector status", {31'd0, rv[0]}, {31'd0, V_STAT[i]});
    end

    // R2: reference held high for many clocks counts once
    setup(32'd0, 32'd999);
    ref_clk_in = 1'b1;
    repeat (30) @(negedge clk);
    ref_clk_in = 1'b0;
    repeat (4) @(negedge clk);
    rd(3'd3, rv); chk("R2 held high", rv, 32'd1);

    // R1: other mode code does not count
    wr(3'd1, 32'd0);
    wr(3'd0, 32'd2);
    wr(3'd3, 32'd7);
    wr(3'd1, 32'd1);
    pulse(); pulse();
    rd(3'd3, rv); chk("R1 wrong mode", rv, 32'd7);
    // R1: run bit clear does not count
    wr(3'd1, 32'd0);
    wr(3'd0, 32'd1);
    pulse();
    rd(3'd3, rv); chk("R1 disabled", rv, 32'd7);

    // R8: mode and compare locked while running
    wr(3'd2, 32'd50);
    wr(3'd1, 32'd1);
    wr(3'd0, 32'd3);
    wr(3'd2, 32'd77);
    rd(3'd0, rv); chk("R8 mode locked", rv, 32'd1);
    rd(3'd2, rv); chk("R8 compare locked", rv, 32'd50);
    pulse();
    rd(3'd3, rv); chk("R8 still counting", rv, 32'd8);

    // R7: stall with halt freezes; halt alone does not
    wr(3'd1, 32'd3);
    dbg_halt = 1'b1;
    pulse();
    rd(3'd3, rv); chk("R7 stalled", rv, 32'd8);
    wr(3'd1, 32'd1);
    pulse();
    rd(3'd3, rv); chk("R7 halt without stall", rv, 32'd9);
    dbg_halt = 1'b0;

    // R6: mask gating
    setup(32'd49, 32'd50);
    wr(3'd4, 32'd0);
    pulse();
    rd(3'd5, rv); chk("R6 raw set", {31'd0, rv[0]}, 32'd1);
    chk("R6 irq masked", {31'd0, irq_o}, 32'd0);
    wr(3'd4, 32'd1);
    repeat (2) @(negedge clk);
    chk("R6 irq unmasked", {31'd0, irq_o}, 32'd1);
    wr(3'd6, 32'd1);
    repeat (2) @(negedge clk);
    chk("R6 irq after clear", {31'd0, irq_o}, 32'd0);
    rd(3'd5, rv); chk("R4 plain clear", {31'd0, rv[0]}, 32'd0);
    wr(3'd4, 32'd0);

    // R4: clear in the same cycle as a new match
    setup(32'd49, 32'd50);
    ref_clk_in = 1'b1;
    repeat (3) @(negedge clk);
    reg_we = 1'b1; reg_waddr = 3'd6; reg_wdata = 32'd1;
    @(negedge clk);
    reg_we = 1'b0;
    repeat (3) @(negedge clk);
    ref_clk_in = 1'b0;
    repeat (4) @(negedge clk);
    rd(3'd3, rv); chk("R4 collision count", rv, 32'd50);
    rd(3'd5, rv); chk("R4 collision keeps status", {31'd0, rv[0]}, 32'd1);
    wr(3'd6, 32'd1);
    rd(3'd5, rv); chk("R4 later clear", {31'd0, rv[0]}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule